// File: doc/BRIEF.md
# Saturating Up/Down Position Selector

This block stands in for a multi-position rotary switch. It keeps a small position value that steps up or down under two push-buttons. A third push-button jumps straight to a position set on a configuration bus. The position drives a one-hot select bus with one line per position, which external analog switches use to pick a tap.

The three key inputs are raw mechanical contacts. Each one is synchronised to the clock and debounced, and its debounced rising edge counts as one press. An up or down press first sets a direction latch. The step itself is applied one cycle later, using the settled direction. The count saturates at both ends and never wraps. Reset loads the preset value rather than zero. A separate output shows whether the position lies in the upper half of the range.

Top module: `tone_pos_sel`

## Requirements
- R1: While reset is asserted and after it is released, the position equals `preset_val`, and `dir_up` is 0.
- R2: `sel_onehot` has exactly one bit set at all times, and bit p is set when the position is p (bit 0 is position 0).
- R3: Each accepted up press raises the position by exactly one.
- R4: Each accepted down press lowers the position by exactly one.
- R5: With the position at 7, up presses leave it at 7.
- R6: With the position at 0, down presses leave it at 0.
- R7: A preset press loads the value on `preset_val`. A change on `preset_val` without a press does not move the position.
- R8: A key level counts only after it has stayed stable for `DEB_CYCLES` clocks. A bouncing press gives one step, and a pulse shorter than `DEB_CYCLES` gives none.
- R9: Holding a key down gives one step only.
- R10: `dir_up` becomes 1 on an accepted up press and 0 on an accepted down press. The step strobe follows the direction update by one cycle.
- R11: When presses are accepted in the same cycle, preset takes priority over up, and up takes priority over down.
- R12: `upper_half` is 1 when the position is 4 or more, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_up_raw | input | 1 | Raw up key, active high |
| key_dn_raw | input | 1 | Raw down key, active high |
| key_pre_raw | input | 1 | Raw preset key, active high |
| preset_val | input | POS_W (3) | Position loaded at reset and on a preset press |
| sel_onehot | output | 2**POS_W (8) | One-hot position select |
| upper_half | output | 1 | High when the position is in the upper half of the range |
| dir_up | output | 1 | Direction latch: 1 means up, 0 means down |

## Verification
The assertions check four things on every cycle. The select bus stays one-hot and agrees with the half-range flag. The position never wraps and moves by at most one step unless a preset load occurs. A preset load lands the sampled bus value. Every step strobe is preceded by a direction update. Only the bench scenarios can show the behaviour that spans many cycles: debounce filtering of bounces and short glitches, one step per held press, the press priorities, and the ignored presses at both ends of the range.

// File: rtl/tone_pos_sel.sv
module tone_pos_sel #(
  parameter int POS_W      = 3,
  parameter int DEB_CYCLES = 16,
  localparam int NPOS      = 1 << POS_W,
  localparam int CW        = $clog2(DEB_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_up_raw,
  input  logic             key_dn_raw,
  input  logic             key_pre_raw,
  input  logic [POS_W-1:0] preset_val,
  output logic [NPOS-1:0]  sel_onehot,
  output logic             upper_half,
  output logic             dir_up
);

  localparam logic [POS_W-1:0] POS_MAX = POS_W'(NPOS - 1);

  logic [2:0] raw;
  logic [2:0] deb, deb_q, rise;
  logic       pre_rise, up_go, dn_go;
  logic       step_q, dir_q;
  logic [POS_W-1:0] pos_q;

  assign raw = {key_pre_raw, key_dn_raw, key_up_raw};

  for (genvar k = 0; k < 3; k++) begin : g_key
    logic s1, s2;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1     <= 1'b0;
        s2     <= 1'b0;
        deb[k] <= 1'b0;
        cnt    <= '0;
      end else begin
        s1 <= raw[k];
        s2 <= s1;
        if (s2 == deb[k]) begin
          cnt <= '0;
        end else if (cnt == CW'(DEB_CYCLES - 1)) begin
          deb[k] <= s2;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) deb_q <= '0;
    else        deb_q <= deb;

  assign rise     = deb & ~deb_q;
  assign pre_rise = rise[2];
  assign up_go    = rise[0] & ~rise[2];
  assign dn_go    = rise[1] & ~rise[0] & ~rise[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      step_q <= up_go | dn_go;
      if (up_go)      dir_q <= 1'b1;
      else if (dn_go) dir_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= preset_val;
    end else if (pre_rise) begin
      pos_q <= preset_val;
    end else if (step_q) begin
      if (dir_q && pos_q != POS_MAX)       pos_q <= pos_q + 1'b1;
      else if (!dir_q && pos_q != '0)      pos_q <= pos_q - 1'b1;
    end
  end

  assign sel_onehot = NPOS'(1) << pos_q;
  assign upper_half = pos_q[POS_W-1];
  assign dir_up     = dir_q;

endmodule

module tone_pos_sel_chk #(
  parameter int POS_W = 3,
  localparam int NPOS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] preset_val,
  input logic             pre_rise,
  input logic             step,
  input logic             go,
  input logic [NPOS-1:0]  sel,
  input logic             upper
);
  localparam logic [POS_W-1:0] PMAX = POS_W'(NPOS - 1);

  // R2
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  // R12
  upper_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upper == (sel[NPOS-1:NPOS/2] != '0));

  // R5
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == PMAX && !pre_rise) |=> pos != '0);

  // R6
  no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0 && !pre_rise) |=> pos != PMAX);

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_rise |=> (pos == $past(pos) || pos == $past(pos) + 1'b1 || pos == $past(pos) - 1'b1));

  // R7
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_rise |=> pos == $past(preset_val));

  // R10
  dir_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $past(go));
endmodule

bind tone_pos_sel tone_pos_sel_chk #(.POS_W(POS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .pos(pos_q), .preset_val(preset_val),
  .pre_rise(pre_rise), .step(step_q), .go(up_go | dn_go),
  .sel(sel_onehot), .upper(upper_half)
);

// File: tb/tone_pos_sel_tb.sv
`timescale 1ns/1ps
module tone_pos_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, pre = 1'b0;
  logic [2:0] pval = 3'd5;
  logic [7:0] sel;
  logic upper, dir;
  int tests = 0, fails = 0;
  int exp_pos;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_pos_sel dut_i (
    .clk(clk), .rst_n(rst_n), .key_up_raw(up), .key_dn_raw(dn),
    .key_pre_raw(pre), .preset_val(pval), .sel_onehot(sel),
    .upper_half(upper), .dir_up(dir)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_pos(string req);
    chk(req, int'(sel), 1 << exp_pos);
    chk({req, "/R12"}, int'(upper), int'(exp_pos >= 4));
  endtask

  task automatic press(logic [2:0] m, int hold);
    {pre, dn, up} = m;
    repeat (hold) @(negedge clk);
    {pre, dn, up} = 3'b000;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_reset;
    pval = 3'd5;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    exp_pos = 5;
    chk_pos("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_pos("R1 after reset");
    chk("R1 dir", dir, 0);
  endtask

  task automatic t_up_sat;
    press(3'b001, 30); exp_pos = 6; chk_pos("R3 up");
    chk("R10 dir up", dir, 1);
    press(3'b001, 30); exp_pos = 7; chk_pos("R3 up to 7");
    press(3'b001, 30); chk_pos("R5 saturate top");
    press(3'b001, 30); chk_pos("R5 saturate top again");
  endtask

  task automatic t_preset;
    pval = 3'd2;
    repeat (40) @(negedge clk);
    chk_pos("R7 bus change ignored");
    press(3'b100, 30); exp_pos = 2; chk_pos("R7 preset press");
  endtask

  task automatic t_down_sat;
    press(3'b010, 30); exp_pos = 1; chk_pos("R4 down");
    chk("R10 dir down", dir, 0);
    press(3'b010, 30); exp_pos = 0; chk_pos("R4 down to 0");
    press(3'b010, 30); chk_pos("R6 saturate bottom");
  endtask

  task automatic t_bounce;
    for (int i = 0; i < 10; i++) begin
      up = ~up;
      repeat (2) @(negedge clk);
    end
    up = 1'b1;
    repeat (40) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      up = ~up;
      repeat (2) @(negedge clk);
    end
    up = 1'b0;
    repeat (40) @(negedge clk);
    exp_pos = 1; chk_pos("R8 bounce one step");
    up = 1'b1;
    repeat (5) @(negedge clk);
    up = 1'b0;
    repeat (40) @(negedge clk);
    chk_pos("R8 short glitch ignored");
  endtask

  task automatic t_hold;
    press(3'b001, 300); exp_pos = 2; chk_pos("R9 held key one step");
  endtask

  task automatic t_priority;
    press(3'b011, 30); exp_pos = 3; chk_pos("R11 up over down");
    chk("R11 dir", dir, 1);
    pval = 3'd6;
    press(3'b101, 30); exp_pos = 6; chk_pos("R11 preset over up");
    press(3'b010, 30); exp_pos = 5; chk_pos("R4 down from 6");
    press(3'b010, 30); exp_pos = 4; chk_pos("R12 at 4");
    press(3'b010, 30); exp_pos = 3; chk_pos("R12 at 3");
  endtask

  initial begin
    t_reset();
    t_up_sat();
    t_preset();
    t_down_sat();
    t_bounce();
    t_hold();
    t_priority();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule